// File: doc/BRIEF.md
# Static Dataflow Operand-Matching Store

This block holds a small array of instruction templates for a static dataflow processor. Each template has an opcode, a left and a right operand slot, and two destination fields. Each operand slot has a presence bit. Tokens arrive on a valid/ready input. A token carries a template index, a port bit that selects the left or right slot, and a data value. Execution is driven only by data: a template fires when the operands its opcode needs are present. There is no program counter.

A token that completes a template does not wait in the slot. The block reads the stored partner operand, clears both presence bits and runs a small integer ALU step. It reports the firing (opcode and both operands) for one cycle. It then sends the result as a new token to each enabled destination, on a valid/ready output, with destination 0 first. Each arc owns exactly one slot, so a token aimed at an occupied slot is held off with ready low. Software or a loader writes templates through a separate load port.

Top module: `dfm_store`

## Requirements
- R1: While reset is high and in the cycle after it, `out_valid` and `fire_valid` are low. Reset clears every presence bit.
- R2: A cycle with `ld_valid` high writes the opcode and both destination fields of template `ld_index` and clears both of its presence bits. `tk_ready` is low in any cycle where `ld_valid` is high.
- R3: On a binary template, a token accepted into an empty slot is stored. Nothing fires and no result token appears.
- R4: A token aimed at a slot whose presence bit is set sees `tk_ready` low. It does not overwrite the stored value.
- R5: A binary template fires when the token that fills its second slot is accepted. In the next cycle `fire_valid` is high for exactly one cycle, with `fire_opcode`, `fire_left` and `fire_right`. Both presence bits are then clear, so the next token to that template is stored again.
- R6: Opcodes whose two upper bits are 11 are unary. They fire on a left token alone and report `fire_right` as zero. A right-port token (port bit 1) to a unary template is accepted and has no effect.
- R7: The opcode encoding is 0 add, 1 left minus right, 2 low half of the product, 3 AND, 4 OR, 5 XOR, 6 pass left, 7 negate left. Arithmetic is modulo 2^DW.
- R8: A destination field is {enable, port, index}, with port 0 = left. A firing emits one result token per enabled destination, on consecutive cycles when `out_ready` is high. Destination 0 goes first, and the first token is valid in the cycle after the firing. A firing with both destinations disabled emits nothing.
- R9: While `out_valid` is high and `out_ready` low, the output token holds steady. A token that would fire is refused (`tk_ready` low) until the output stage can take a new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Template load strobe |
| ld_index | input | IW | Template being loaded |
| ld_opcode | input | 3 | Opcode to load |
| ld_d0_en | input | 1 | Destination 0 enable |
| ld_d0_index | input | IW | Destination 0 template |
| ld_d0_port | input | 1 | Destination 0 port (0 left, 1 right) |
| ld_d1_en | input | 1 | Destination 1 enable |
| ld_d1_index | input | IW | Destination 1 template |
| ld_d1_port | input | 1 | Destination 1 port |
| tk_valid | input | 1 | Incoming token valid |
| tk_ready | output | 1 | Incoming token accepted this cycle |
| tk_index | input | IW | Incoming token template index |
| tk_port | input | 1 | Incoming token port |
| tk_value | input | DW | Incoming token value |
| out_valid | output | 1 | Result token valid |
| out_ready | input | 1 | Result token consumer ready |
| out_index | output | IW | Result token template index |
| out_port | output | 1 | Result token port |
| out_value | output | DW | Result token value |
| fire_valid | output | 1 | A template fired last cycle |
| fire_opcode | output | 3 | Opcode of the firing template |
| fire_left | output | DW | Left operand used |
| fire_right | output | DW | Right operand used (zero for unary) |

## Verification
The bench sweeps every opcode against several operand pairs and three destination patterns. It computes each result arithmetically. A wrong ALU encoding or a swapped subtraction would show a wrong `out_value`. A design that emitted destination 1 first, or sent a token for a disabled field, would show up in the index sequence. Other checks send a second token to a full slot, reload a half-filled template, send a right token to a unary template, and block the output while a second firing waits. A design that overwrote slots, kept stale presence bits, or fired over a blocked output stage would report the wrong left operand, a spurious firing or a lost token.

// File: rtl/dfm_pkg.sv
package dfm_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_MUL  = 3'd2,
        OP_AND  = 3'd3,
        OP_OR   = 3'd4,
        OP_XOR  = 3'd5,
        OP_PASS = 3'd6,
        OP_NEG  = 3'd7
    } op_e;

    localparam logic PORT_L = 1'b0;
    localparam logic PORT_R = 1'b1;

    function automatic logic op_is_unary(op_e op);
        return op[2:1] == 2'b11;
    endfunction

endpackage

// File: rtl/dfm_alu.sv
module dfm_alu
    import dfm_pkg::*;
#(
    parameter int DW = 16
) (
    input  op_e           op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);
    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_MUL:  y = a * b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_PASS: y = a;
            OP_NEG:  y = -a;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/dfm_tpl_store.sv
module dfm_tpl_store
    import dfm_pkg::*;
#(
    parameter int N   = 8,
    parameter int DW  = 16,
    parameter int IW  = 3,
    localparam int DCW = IW + 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ld_en,
    input  logic [IW-1:0]        ld_idx,
    input  op_e                  ld_op,
    input  logic [1:0][DCW-1:0]  ld_dst,
    input  logic                 wr_en,
    input  logic [IW-1:0]        wr_idx,
    input  logic                 wr_port,
    input  logic [DW-1:0]        wr_val,
    input  logic                 clr_en,
    input  logic [IW-1:0]        clr_idx,
    input  logic [IW-1:0]        rd_idx,
    output op_e                  rd_op,
    output logic [1:0][DCW-1:0]  rd_dst,
    output logic                 rd_pres_l,
    output logic                 rd_pres_r,
    output logic [DW-1:0]        rd_val_l,
    output logic [DW-1:0]        rd_val_r
);
    op_e                 op_q    [N];
    logic [1:0][DCW-1:0] dst_q   [N];
    logic                pres_lq [N];
    logic                pres_rq [N];
    logic [DW-1:0]       val_lq  [N];
    logic [DW-1:0]       val_rq  [N];

    for (genvar i = 0; i < N; i++) begin : g_entry
        logic hit_ld, hit_wr, hit_clr;
        assign hit_ld  = ld_en  && (ld_idx  == IW'(i));
        assign hit_wr  = wr_en  && (wr_idx  == IW'(i));
        assign hit_clr = clr_en && (clr_idx == IW'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                op_q[i]    <= OP_ADD;
                dst_q[i]   <= '0;
                pres_lq[i] <= 1'b0;
                pres_rq[i] <= 1'b0;
            end else if (hit_ld) begin
                op_q[i]    <= ld_op;
                dst_q[i]   <= ld_dst;
                pres_lq[i] <= 1'b0;
                pres_rq[i] <= 1'b0;
            end else if (hit_clr) begin
                pres_lq[i] <= 1'b0;
                pres_rq[i] <= 1'b0;
            end else if (hit_wr) begin
                if (wr_port == PORT_R) pres_rq[i] <= 1'b1;
                else                   pres_lq[i] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (hit_wr && wr_port == PORT_L) val_lq[i] <= wr_val;
            if (hit_wr && wr_port == PORT_R) val_rq[i] <= wr_val;
        end
    end

    assign rd_op     = op_q[rd_idx];
    assign rd_dst    = dst_q[rd_idx];
    assign rd_pres_l = pres_lq[rd_idx];
    assign rd_pres_r = pres_rq[rd_idx];
    assign rd_val_l  = val_lq[rd_idx];
    assign rd_val_r  = val_rq[rd_idx];
endmodule

// File: rtl/dfm_emit.sv
module dfm_emit #(
    parameter int DW  = 16,
    parameter int IW  = 3,
    localparam int DCW = IW + 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load_en,
    input  logic [DW-1:0]       res_val,
    input  logic [1:0][DCW-1:0] dst_cfg,
    input  logic                out_ready,
    output logic                out_valid,
    output logic [IW-1:0]       out_index,
    output logic                out_port,
    output logic [DW-1:0]       out_value,
    output logic                free
);
    localparam int EN_BIT   = DCW - 1;
    localparam int PORT_BIT = IW;

    logic [1:0]           pend_q;
    logic [DW-1:0]        val_q;
    logic [1:0][DCW-1:0]  dst_q;
    logic                 sel;

    assign sel       = ~pend_q[0];
    assign out_valid = |pend_q;
    assign out_index = dst_q[sel][IW-1:0];
    assign out_port  = dst_q[sel][PORT_BIT];
    assign out_value = val_q;
    assign free      = (pend_q != 2'b11) && ((pend_q == 2'b00) || out_ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 2'b00;
        end else if (load_en) begin
            pend_q <= {dst_cfg[1][EN_BIT], dst_cfg[0][EN_BIT]};
        end else if (out_valid && out_ready) begin
            pend_q[sel] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (load_en) begin
            val_q <= res_val;
            dst_q <= dst_cfg;
        end
    end
endmodule

// File: rtl/dfm_store.sv
module dfm_store
    import dfm_pkg::*;
#(
    parameter int  N_TPL = 8,
    parameter int  DW    = 16,
    localparam int IW    = (N_TPL > 1) ? $clog2(N_TPL) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_valid,
    input  logic [IW-1:0] ld_index,
    input  logic [2:0]    ld_opcode,
    input  logic          ld_d0_en,
    input  logic [IW-1:0] ld_d0_index,
    input  logic          ld_d0_port,
    input  logic          ld_d1_en,
    input  logic [IW-1:0] ld_d1_index,
    input  logic          ld_d1_port,
    input  logic          tk_valid,
    output logic          tk_ready,
    input  logic [IW-1:0] tk_index,
    input  logic          tk_port,
    input  logic [DW-1:0] tk_value,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [IW-1:0] out_index,
    output logic          out_port,
    output logic [DW-1:0] out_value,
    output logic          fire_valid,
    output logic [2:0]    fire_opcode,
    output logic [DW-1:0] fire_left,
    output logic [DW-1:0] fire_right
);
    localparam int DCW = IW + 2;

    logic [1:0][DCW-1:0] ld_dst;
    op_e                 cur_op;
    logic [1:0][DCW-1:0] cur_dst;
    logic                pres_l, pres_r;
    logic [DW-1:0]       sval_l, sval_r;
    logic                unary, completes, drop, occupied;
    logic                accept, fire, wr_en, emit_free;
    logic [DW-1:0]       opnd_l, opnd_r, alu_y;

    assign ld_dst[0] = {ld_d0_en, ld_d0_port, ld_d0_index};
    assign ld_dst[1] = {ld_d1_en, ld_d1_port, ld_d1_index};

    dfm_tpl_store #(.N(N_TPL), .DW(DW), .IW(IW)) u_store (
        .clk       (clk),
        .rst       (rst),
        .ld_en     (ld_valid),
        .ld_idx    (ld_index),
        .ld_op     (op_e'(ld_opcode)),
        .ld_dst    (ld_dst),
        .wr_en     (wr_en),
        .wr_idx    (tk_index),
        .wr_port   (tk_port),
        .wr_val    (tk_value),
        .clr_en    (fire),
        .clr_idx   (tk_index),
        .rd_idx    (tk_index),
        .rd_op     (cur_op),
        .rd_dst    (cur_dst),
        .rd_pres_l (pres_l),
        .rd_pres_r (pres_r),
        .rd_val_l  (sval_l),
        .rd_val_r  (sval_r)
    );

    // Matching decision for the token at the input.
    always_comb begin
        unary     = op_is_unary(cur_op);
        drop      = (tk_port == PORT_R) && unary;
        occupied  = (tk_port == PORT_R) ? pres_r : pres_l;
        completes = (tk_port == PORT_L) ? (unary || pres_r) : (!unary && pres_l);
        tk_ready  = !ld_valid &&
                    (drop || (!occupied && (!completes || emit_free)));
        accept    = tk_valid && tk_ready;
        fire      = accept && completes && !drop;
        wr_en     = accept && !completes && !drop;
        opnd_l    = (tk_port == PORT_L) ? tk_value : sval_l;
        opnd_r    = unary ? '0 : ((tk_port == PORT_R) ? tk_value : sval_r);
    end

    dfm_alu #(.DW(DW)) u_alu (
        .op (cur_op),
        .a  (opnd_l),
        .b  (opnd_r),
        .y  (alu_y)
    );

    dfm_emit #(.DW(DW), .IW(IW)) u_emit (
        .clk       (clk),
        .rst       (rst),
        .load_en   (fire),
        .res_val   (alu_y),
        .dst_cfg   (cur_dst),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_index (out_index),
        .out_port  (out_port),
        .out_value (out_value),
        .free      (emit_free)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fire_valid <= 1'b0;
        end else begin
            fire_valid <= fire;
        end
    end

    always_ff @(posedge clk) begin
        if (fire) begin
            fire_opcode <= cur_op;
            fire_left   <= opnd_l;
            fire_right  <= opnd_r;
        end
    end
endmodule

// File: rtl/dfm_store_chk.sv
module dfm_store_chk #(
    parameter int DW = 16,
    parameter int IW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          ld_valid,
    input logic          tk_valid,
    input logic          tk_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [IW-1:0] out_index,
    input logic          out_port,
    input logic [DW-1:0] out_value,
    input logic          fire_valid,
    input logic [2:0]    fire_opcode,
    input logic [DW-1:0] fire_right
);
    // R1: quiet outputs right after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !fire_valid));

    // R2: loading blocks token acceptance
    p_load_blocks_r2: assert property (@(posedge clk) disable iff (rst)
        ld_valid |-> !tk_ready);

    // R5: a firing report follows an accepted token
    p_fire_cause_r5: assert property (@(posedge clk) disable iff (rst)
        fire_valid |-> $past(tk_valid && tk_ready));

    // R6: unary firings report a zero right operand
    p_unary_right_r6: assert property (@(posedge clk) disable iff (rst)
        (fire_valid && fire_opcode[2:1] == 2'b11) |-> (fire_right == '0));

    // R9: a stalled output token holds steady
    p_out_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_index) && $stable(out_port) && $stable(out_value)));
endmodule

bind dfm_store dfm_store_chk #(.DW(DW), .IW(IW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ld_valid    (ld_valid),
    .tk_valid    (tk_valid),
    .tk_ready    (tk_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_index   (out_index),
    .out_port    (out_port),
    .out_value   (out_value),
    .fire_valid  (fire_valid),
    .fire_opcode (fire_opcode),
    .fire_right  (fire_right)
);

// File: tb/dfm_store_tb.sv
module dfm_store_tb;
    localparam int CLK_P = 10;
    localparam int N_TPL = 8;
    localparam int DW    = 16;
    localparam int IW    = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_P/2) clk = ~clk;

    logic          ld_valid = 1'b0;
    logic [IW-1:0] ld_index = '0;
    logic [2:0]    ld_opcode = '0;
    logic          ld_d0_en = 1'b0, ld_d0_port = 1'b0;
    logic [IW-1:0] ld_d0_index = '0;
    logic          ld_d1_en = 1'b0, ld_d1_port = 1'b0;
    logic [IW-1:0] ld_d1_index = '0;
    logic          tk_valid = 1'b0;
    logic          tk_ready;
    logic [IW-1:0] tk_index = '0;
    logic          tk_port = 1'b0;
    logic [DW-1:0] tk_value = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [IW-1:0] out_index;
    logic          out_port;
    logic [DW-1:0] out_value;
    logic          fire_valid;
    logic [2:0]    fire_opcode;
    logic [DW-1:0] fire_left, fire_right;

    dfm_store #(.N_TPL(N_TPL), .DW(DW)) u_dut (.*);

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_alu(int op, logic [DW-1:0] a, logic [DW-1:0] b);
        case (op)
            0: return a + b;
            1: return a - b;
            2: return DW'(a * b);
            3: return a & b;
            4: return a | b;
            5: return a ^ b;
            6: return a;
            default: return -a;
        endcase
    endfunction

    task automatic load(int idx, int op, bit e0, int i0, bit p0, bit e1, int i1, bit p1);
        ld_valid = 1'b1; ld_index = IW'(idx); ld_opcode = 3'(op);
        ld_d0_en = e0; ld_d0_index = IW'(i0); ld_d0_port = p0;
        ld_d1_en = e1; ld_d1_index = IW'(i1); ld_d1_port = p1;
        #1;
        chk("R2", "tk_ready during load", int'(tk_ready), 0);
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic send(int idx, bit port, logic [DW-1:0] val);
        tk_valid = 1'b1; tk_index = IW'(idx); tk_port = port; tk_value = val;
        #1;
        while (!tk_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        tk_valid = 1'b0;
    endtask

    task automatic expect_tok(string tag, int idx, bit port, logic [DW-1:0] val);
        chk(tag, "out_valid", int'(out_valid), 1);
        chk(tag, "out_index", int'(out_index), idx);
        chk(tag, "out_port", int'(out_port), int'(port));
        chk(tag, "out_value", int'(out_value), int'(val));
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "out_valid in reset", int'(out_valid), 0);
        chk("R1", "fire_valid in reset", int'(fire_valid), 0);
        rst = 1'b0;
        #1;
        chk("R1", "tk_ready after reset", int'(tk_ready), 1);
        @(negedge clk);
        chk("R1", "out_valid after reset", int'(out_valid), 0);

        // R7 / R8 / R5 / R6 sweep over all opcodes and destination patterns
        for (int op = 0; op < 8; op++) begin
            for (int k = 0; k < 3; k++) begin
                logic [DW-1:0] a, b, y;
                bit e0, e1, p0, p1, un;
                int i0, i1;
                a  = DW'(op * 1234 + k * 4097 + 7);
                b  = (k == 2) ? 16'hFFFF : DW'(k * 31 - op * 5 + 3);
                e0 = (k != 2); e1 = (k != 1);
                p0 = bit'(k % 2); p1 = !p0;
                i0 = (op + 1) % N_TPL; i1 = (op + 3) % N_TPL;
                un = (op >= 6);
                load(op, op, e0, i0, p0, e1, i1, p1);
                if (un) begin
                    send(op, 1'b1, b);
                    chk("R6", "no fire on right to unary", int'(fire_valid), 0);
                    chk("R6", "no token on right to unary", int'(out_valid), 0);
                    send(op, 1'b0, a);
                end else begin
                    send(op, 1'b0, a);
                    chk("R3", "no fire on first operand", int'(fire_valid), 0);
                    chk("R3", "no token on first operand", int'(out_valid), 0);
                    send(op, 1'b1, b);
                end
                y = exp_alu(op, a, b);
                chk("R5", "fire_valid", int'(fire_valid), 1);
                chk("R5", "fire_opcode", int'(fire_opcode), op);
                chk("R5", "fire_left", int'(fire_left), int'(a));
                chk(un ? "R6" : "R5", "fire_right", int'(fire_right), un ? 0 : int'(b));
                if (e0) expect_tok("R7", i0, p0, y);
                if (e1) expect_tok("R8", i1, p1, y);
                chk("R8", "no extra token", int'(out_valid), 0);
                chk("R5", "single fire pulse", int'(fire_valid), 0);
            end
        end

        // R4: occupied slot stalls, value preserved
        load(1, 0, 1'b1, 5, 1'b0, 1'b0, 0, 1'b0);
        send(1, 1'b0, 16'd5);
        tk_valid = 1'b1; tk_index = 3'd1; tk_port = 1'b0; tk_value = 16'd9;
        #1;
        chk("R4", "tk_ready to full slot", int'(tk_ready), 0);
        @(negedge clk); #1;
        chk("R4", "tk_ready to full slot later", int'(tk_ready), 0);
        tk_valid = 1'b0;
        @(negedge clk);
        send(1, 1'b1, 16'd3);
        chk("R4", "left kept", int'(fire_left), 5);
        expect_tok("R4", 5, 1'b0, 16'd8);
        // R5: presence cleared after firing
        send(1, 1'b0, 16'd20);
        chk("R5", "stored again after fire", int'(fire_valid), 0);
        send(1, 1'b1, 16'd1);
        chk("R5", "refire", int'(fire_valid), 1);
        expect_tok("R5", 5, 1'b0, 16'd21);

        // R2: reload clears presence
        load(4, 1, 1'b1, 2, 1'b1, 1'b0, 0, 1'b0);
        send(4, 1'b0, 16'd100);
        load(4, 1, 1'b1, 2, 1'b1, 1'b0, 0, 1'b0);
        send(4, 1'b1, 16'd30);
        chk("R2", "no fire after reload", int'(fire_valid), 0);
        send(4, 1'b0, 16'd50);
        chk("R2", "fire with new left", int'(fire_left), 50);
        expect_tok("R2", 2, 1'b1, 16'd20);

        // R8: both destinations disabled
        load(5, 5, 1'b0, 0, 1'b0, 1'b0, 0, 1'b0);
        send(5, 1'b0, 16'd3);
        send(5, 1'b1, 16'd5);
        chk("R8", "fire without dests", int'(fire_valid), 1);
        chk("R8", "no token without dests", int'(out_valid), 0);

        // R9: backpressure
        load(2, 0, 1'b1, 6, 1'b1, 1'b1, 7, 1'b0);
        load(3, 6, 1'b1, 0, 1'b0, 1'b0, 0, 1'b0);
        out_ready = 1'b0;
        send(2, 1'b0, 16'd10);
        send(2, 1'b1, 16'd15);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk("R9", "held valid", int'(out_valid), 1);
            chk("R9", "held index", int'(out_index), 6);
            chk("R9", "held value", int'(out_value), 25);
        end
        tk_valid = 1'b1; tk_index = 3'd3; tk_port = 1'b0; tk_value = 16'd77;
        #1;
        chk("R9", "firing token refused while full", int'(tk_ready), 0);
        out_ready = 1'b1;
        #1;
        chk("R9", "still refused with two pending", int'(tk_ready), 0);
        @(negedge clk);
        chk("R9", "second dest index", int'(out_index), 7);
        chk("R9", "second dest port", int'(out_port), 0);
        #1;
        chk("R9", "accepted when slot drains", int'(tk_ready), 1);
        @(negedge clk);
        tk_valid = 1'b0;
        chk("R9", "stalled token fired", int'(fire_valid), 1);
        expect_tok("R9", 0, 1'b0, 16'd77);
        chk("R9", "drained", int'(out_valid), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule